// File: doc/BRIEF.md
# Footswitch Bypass Relay Sequencer with Timed Audio Mute

This block sits between a pedal's footswitch, its true-bypass relay and the stereo sample path of the effect processor. Each clean press of the footswitch flips the pedal between bypassed and effect-active. The relay is never switched while samples are moving: the block first raises a pause request to the sample transfer logic, holds it for a programmable frame interval, flips the relay, and holds the pause for another frame interval before releasing it.

Switching the relay produces a short electrical spike of roughly two milliseconds, and an effect such as a reverb would stretch it into an audible crash. To keep it out of the output, every accepted press starts a one-shot mute timer. While the timer runs, or while the pause is up, the stereo samples leaving the block are forced to zero. Sample strobes still pass, so the frame rhythm downstream never changes. A press that lands inside a running window restarts the timer. The raw footswitch is synchronized to the clock and must hold a new level for a set number of cycles before it counts.

Top module: `bypass_mute_ctrl`

## Requirements
- R1: After reset the relay drive is low (effect bypassed) and the pause request is low.
- R2: Each accepted press toggles the relay drive. High means effect active and low means bypassed.
- R3: Press detection works on the synchronized level. A high level counts as a press only once it has held for DEB_CNT consecutive cycles. Shorter pulses are ignored, and a release never counts as a press.
- R4: An accepted press zeroes both output sample channels for exactly MUTE_CYC consecutive output cycles.
- R5: Outside the mute window, each output channel equals the corresponding input channel one cycle earlier.
- R6: The pause request is high for exactly FRAME_CYC cycles before the relay drive changes. It stays high for exactly FRAME_CYC cycles from the cycle of the change.
- R7: A press accepted while the mute window runs restarts the window. The zero run then lasts MUTE_CYC cycles past the second press, so its length is the spacing between the two pause rises plus MUTE_CYC.
- R8: If a second press is accepted before the relay flips, the two presses cancel. The relay stays where it was, and only one pause period occurs.
- R9: The output sample strobe equals the input strobe one cycle earlier, whether or not the block is muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsw_raw | input | 1 | Raw footswitch level, high while pressed |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | W | Left input sample |
| in_right | input | W | Right input sample |
| relay_on | output | 1 | Relay drive, high when the effect is active |
| xfer_pause | output | 1 | Request to hold the sample transfer |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | W | Left output sample, zero while muted |
| out_right | output | W | Right output sample, zero while muted |

## Verification
The footswitch is driven with a sweep of pulse widths from one cycle up to one short of the debounce count, then with holds at and above the debounce count. This separates rejected glitches from real presses and shows that a release produces no event. Isolated presses measure the pause lead, the pause tail and the length of the zero run. A second press placed after the relay has flipped but inside the mute window shows the timer restarting. A second press placed before the flip shows cancellation, with one pause period and no relay change. The input samples form a never-zero counting ramp with a gapped strobe, so any zero at the output can only come from muting, and any other value must equal the previous input.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LEAD = 2'd1,
    SQ_POST = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fsw_debounce.sv
module fsw_debounce #(
  parameter int DEB_CNT = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic press
);
  localparam int CW = $clog2(DEB_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CNT - 1);

  logic          s1_q, s2_q, stable_q, stable_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          press_n;

  always_comb begin
    stable_n = stable_q;
    cnt_n    = cnt_q;
    press_n  = 1'b0;
    if (s2_q == stable_q) begin
      cnt_n = '0;
    end else if (cnt_q == LAST) begin
      stable_n = s2_q;
      cnt_n    = '0;
      press_n  = s2_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      s2_q     <= 1'b0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press    <= 1'b0;
    end else begin
      s1_q     <= raw;
      s2_q     <= s1_q;
      stable_q <= stable_n;
      cnt_q    <= cnt_n;
      press    <= press_n;
    end
  end
endmodule

// File: rtl/bypass_seq.sv
module bypass_seq
  import bmc_pkg::*;
#(
  parameter int FRAME_CYC = 2604
) (
  input  logic clk,
  input  logic rst_n,
  input  logic press,
  output logic relay,
  output logic pause
);
  localparam int FW = $clog2(FRAME_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FRAME_CYC - 1);

  seq_state_e    state_q, state_n;
  logic [FW-1:0] cnt_q, cnt_n;
  logic          want_q, want_n;
  logic          relay_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    relay_n = relay;
    want_n  = want_q ^ press;
    case (state_q)
      SQ_IDLE: begin
        if (relay != want_q) begin
          state_n = SQ_LEAD;
          cnt_n   = '0;
        end
      end
      SQ_LEAD: begin
        if (cnt_q == LAST) begin
          state_n = SQ_POST;
          cnt_n   = '0;
          relay_n = want_q;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      SQ_POST: begin
        if (cnt_q == LAST) begin
          state_n = SQ_IDLE;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        state_n = SQ_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      want_q  <= 1'b0;
      relay   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      want_q  <= want_n;
      relay   <= relay_n;
    end
  end

  assign pause = (state_q != SQ_IDLE);
endmodule

// File: rtl/mute_timer.sv
module mute_timer #(
  parameter int MUTE_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic muted
);
  localparam int MW = $clog2(MUTE_CYC + 1);
  localparam logic [MW-1:0] LOAD = MW'(MUTE_CYC);

  logic [MW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start) begin
      cnt_n = LOAD;
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign muted = (cnt_q != '0);
endmodule

// File: rtl/sample_gate.sv
module sample_gate #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mute,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic [W-1:0] left_n, right_n;

  always_comb begin
    left_n  = mute ? '0 : in_left;
    right_n = mute ? '0 : in_right;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      out_left  <= left_n;
      out_right <= right_n;
    end
  end
endmodule

// File: rtl/bypass_mute_ctrl.sv
module bypass_mute_ctrl #(
  parameter int W         = 24,
  parameter int DEB_CNT   = 1250000,
  parameter int FRAME_CYC = 2604,
  parameter int MUTE_CYC  = 250000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsw_raw,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  output logic         relay_on,
  output logic         xfer_pause,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic rst_m_q, rst_sync_n;
  logic press_pulse;
  logic timer_muted;
  logic gate_mute;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  fsw_debounce #(.DEB_CNT(DEB_CNT)) u_deb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw   (fsw_raw),
    .press (press_pulse)
  );

  bypass_seq #(.FRAME_CYC(FRAME_CYC)) u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .press (press_pulse),
    .relay (relay_on),
    .pause (xfer_pause)
  );

  mute_timer #(.MUTE_CYC(MUTE_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (press_pulse),
    .muted (timer_muted)
  );

  assign gate_mute = timer_muted | xfer_pause;

  sample_gate #(.W(W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mute      (gate_mute),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         press,
  input logic         muted,
  input logic         pause,
  input logic         relay,
  input logic         in_valid,
  input logic [W-1:0] in_left,
  input logic [W-1:0] in_right,
  input logic         out_valid,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_relay_paused_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (relay != $past(relay)) |-> (pause && $past(pause)));

  p_mute_on_press_r4: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> muted);

  p_zero_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (muted || pause) |=> (out_left == '0 && out_right == '0));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(muted || pause) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    armed |=> (out_valid == $past(in_valid)));
endmodule

bind bypass_mute_ctrl bmc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .press     (press_pulse),
  .muted     (timer_muted),
  .pause     (xfer_pause),
  .relay     (relay_on),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/bypass_mute_ctrl_bench.sv
`timescale 1ns/1ps
module bypass_mute_ctrl_bench;
  localparam int W  = 16;
  localparam int DB = 4;
  localparam int FR = 24;
  localparam int MU = 100;

  logic         clk;
  logic         rst_n;
  logic         fsw_raw;
  logic         in_valid;
  logic [W-1:0] in_left, in_right;
  logic         relay_on, xfer_pause, out_valid;
  logic [W-1:0] out_left, out_right;

  int checks, errors;
  int cyc;

  bypass_mute_ctrl #(.W(W), .DEB_CNT(DB), .FRAME_CYC(FR), .MUTE_CYC(MU)) u_bypass_mute_ctrl (
    .clk(clk), .rst_n(rst_n), .fsw_raw(fsw_raw),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .relay_on(relay_on), .xfer_pause(xfer_pause),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor state
  int   rises, relay_changes, t_rise, t_relay, lead_len, post_len;
  int   run, last_run, runs_seen;
  int   pass_err, valid_err, pair_err;
  logic prev_pause, prev_relay, mon_on;
  logic [W-1:0] exp_l, exp_r;
  logic exp_v;
  int   ramp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    cyc = 0; rises = 0; relay_changes = 0; t_rise = 0; t_relay = 0;
    lead_len = 0; post_len = 0; run = 0; last_run = 0; runs_seen = 0;
    pass_err = 0; valid_err = 0; pair_err = 0;
    prev_pause = 1'b0; prev_relay = 1'b0; mon_on = 1'b0;
    exp_l = '0; exp_r = '0; exp_v = 1'b0; ramp = 0;
    in_valid = 1'b0; in_left = '0; in_right = '0;
  end

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (xfer_pause && !prev_pause) begin rises++; t_rise = cyc; end
      if (relay_on != prev_relay) begin
        relay_changes++; lead_len = cyc - t_rise; t_relay = cyc;
      end
      if (!xfer_pause && prev_pause) post_len = cyc - t_relay;
      if ((out_left == '0) != (out_right == '0)) pair_err++;
      if (out_left == '0) run++;
      else begin
        if (run > 0) begin last_run = run; runs_seen++; run = 0; end
        if (out_left != exp_l || out_right != exp_r) pass_err++;
      end
      if (out_valid != exp_v) valid_err++;
    end
    prev_pause = xfer_pause;
    prev_relay = relay_on;
    ramp = (ramp % 60000) + 1;
    in_left  = W'(ramp);
    in_right = W'(ramp + 3);
    in_valid = (cyc % 3) != 2;
    exp_l = in_left; exp_r = in_right; exp_v = in_valid;
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hold);
    @(negedge clk);
    fsw_raw = 1'b1;
    wait_cyc(hold);
    fsw_raw = 1'b0;
  endtask

  initial begin
    int base_r, base_c, base_runs, rise1;
    logic rel0;
    checks = 0; errors = 0;
    fsw_raw = 1'b0;
    rst_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    check(relay_on == 1'b0, "R1 relay after reset", relay_on, 0);
    check(xfer_pause == 1'b0, "R1 pause after reset", xfer_pause, 0);
    mon_on = 1'b1;
    wait_cyc(3);

    // R3: glitches shorter than the debounce count
    for (int w = 1; w < DB; w++) begin
      pulse(w);
      wait_cyc(30);
    end
    check(rises == 0, "R3 glitches ignored (pause rises)", rises, 0);
    check(relay_on == 1'b0, "R3 glitches ignored (relay)", relay_on, 0);

    // accepted presses, widths at and above the debounce count
    for (int w = DB; w < DB + 4; w++) begin
      base_r = rises; rel0 = relay_on; base_runs = runs_seen;
      pulse(w);
      wait_cyc(220);
      check(rises == base_r + 1, "R3 single event per press", rises - base_r, 1);
      check(relay_on == !rel0, "R2 relay toggles", relay_on, !rel0);
      check(lead_len == FR, "R6 pause lead", lead_len, FR);
      check(post_len == FR, "R6 pause tail", post_len, FR);
      check(runs_seen == base_runs + 1 && last_run == MU, "R4 mute length", last_run, MU);
    end

    // R7: retrigger inside the mute window, after the flip
    base_c = relay_changes; base_runs = runs_seen;
    pulse(DB + 2);
    wait_cyc(3);
    rise1 = t_rise;
    wait_cyc(55);
    pulse(DB + 1);
    wait_cyc(260);
    check(relay_changes == base_c + 2, "R7 both presses toggle", relay_changes - base_c, 2);
    check(runs_seen == base_runs + 1, "R7 one merged zero run", runs_seen - base_runs, 1);
    check(last_run == (t_rise - rise1) + MU, "R7 restarted window", last_run, (t_rise - rise1) + MU);

    // R8: two presses before the flip cancel
    base_r = rises; base_c = relay_changes; rel0 = relay_on; base_runs = runs_seen;
    @(negedge clk);
    fsw_raw = 1'b1; wait_cyc(5);
    fsw_raw = 1'b0; wait_cyc(6);
    fsw_raw = 1'b1; wait_cyc(6);
    fsw_raw = 1'b0;
    wait_cyc(260);
    check(rises == base_r + 1, "R8 single pause period", rises - base_r, 1);
    check(relay_changes == base_c, "R8 relay unchanged", relay_changes - base_c, 0);
    check(relay_on == rel0, "R8 relay level", relay_on, rel0);
    check(runs_seen == base_runs + 1 && last_run >= MU, "R8 mute still applied", last_run, MU);

    check(pass_err == 0, "R5 passthrough mismatches", pass_err, 0);
    check(pair_err == 0, "R4 channels muted together", pair_err, 0);
    check(valid_err == 0, "R9 strobe mismatches", valid_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule